// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block commits the architectural side effects of taking a trap. When the pipeline raises `trap_req` together with a cause word, an optional faulting address, the PC of the trapping instruction and a snapshot of the current hart state, the unit works out the destination. The trap can go to the supervisor handler, the machine handler, or, for a breakpoint while an external debugger is attached, to the debug ROM. One clock later it presents the new PC, privilege and status word. It also presents the values and write strobes the surrounding CSR file needs.

The cause word carries an interrupt flag in its top bit. The remaining bits form the cause code, which indexes either the interrupt-delegation mask or the exception-delegation mask. The status word uses fixed bit positions, because the stacked enable is selected by using the old privilege code as a bit index into the status word.

The register file itself, instruction execution and software CSR access live outside this block. The consumer writes the registers selected by `commit_dest` during the cycle in which `commit_vld` is high.

Top module: `trap_entry`

## Requirements
- R1: A trap sampled with `trap_req` high at a rising edge is committed in that edge: `commit_vld` is high for exactly the following cycle. With `trap_req` low, `commit_vld`, `badaddr_wr` and `resv_clear` stay low and all data outputs keep their values.
- R2: The delegation mask is `mideleg_in` when cause bit XLEN-1 is set (interrupt) and `medeleg_in` otherwise, indexed by the cause code with the top bit cleared.
- R3: `commit_dest` is 1 (supervisor) only when all three hold: the current privilege is user (00) or supervisor (01), the cause code is below XLEN, and the selected delegation bit is set. Otherwise it is 2 (machine), except for the R8 case.
- R4: On supervisor entry, `nxt_pc` is `stvec_in`, and `cause_out` and `epc_out` take the trap's cause and PC. `badaddr_wr` is high only if `trap_addr_vld` was high, and then `badaddr_out` holds the trap address.
- R5: On supervisor entry, status bit 5 takes the status bit whose index is the old privilege code, bit 8 takes bit 0 of the old privilege, bit 1 is cleared, all other status bits pass through unchanged, and `nxt_prv` is 01.
- R6: On machine entry, `cause_out`, `epc_out` and the address strobe behave as in R4. Status bit 7 takes the status bit indexed by the old privilege code, bits 12:11 take the old privilege, bit 3 is cleared, other bits pass through unchanged, and `nxt_prv` is 11.
- R7: On machine entry, `nxt_pc` is `mtvec_in` when `dbg_cause_in` is zero, and the debug-exception address (default 0x808) otherwise.
- R8: An exception with cause code 3 (breakpoint) while `dbg_attached` is high gives `commit_dest` 3. In that case `nxt_pc` is the debug ROM start (default 0x800), `nxt_prv` is 11, `dbg_cause_out` is 1, `dbg_prv_out` is the old privilege, `epc_out` is the trap PC for the debug PC register, the status word is unchanged, and `badaddr_wr` stays low.
- R9: `resv_clear` pulses with every supervisor or machine entry and stays low for a debug entry.
- R10: After reset all outputs are zero, with `commit_dest` 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap to commit this cycle |
| trap_cause | input | XLEN | Cause word; top bit set for interrupts |
| trap_addr | input | XLEN | Faulting address |
| trap_addr_vld | input | 1 | Trap carries a faulting address |
| trap_epc | input | XLEN | PC of the trapping instruction |
| cur_prv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| cur_status | input | XLEN | Current status word |
| stvec_in | input | XLEN | Supervisor handler base |
| mtvec_in | input | XLEN | Machine handler base |
| medeleg_in | input | XLEN | Exception delegation mask |
| mideleg_in | input | XLEN | Interrupt delegation mask |
| dbg_cause_in | input | 3 | Current debug-cause field |
| dbg_attached | input | 1 | External debugger connected |
| commit_vld | output | 1 | Committed trap values valid this cycle |
| commit_dest | output | 2 | 0 none, 1 supervisor, 2 machine, 3 debug |
| nxt_pc | output | XLEN | New PC |
| nxt_prv | output | 2 | New privilege |
| nxt_status | output | XLEN | New status word |
| cause_out | output | XLEN | Value for the selected cause register |
| epc_out | output | XLEN | Value for the selected EPC or debug PC register |
| badaddr_wr | output | 1 | Write the selected bad-address register |
| badaddr_out | output | XLEN | Value for the bad-address register |
| dbg_cause_out | output | 3 | New debug-cause field on debug entry |
| dbg_prv_out | output | 2 | Privilege saved on debug entry |
| resv_clear | output | 1 | Drop the load reservation |

## Verification
On every cycle the assertions check the following. Commits occur only one cycle after a request. Supervisor destinations never follow machine privilege. Each entry clears the enable of the handler's own level and sets the right privilege. A debug entry leaves the status word untouched. The reservation and address strobes agree with the destination and the request. Only the directed scenarios can show the exact routing decisions: mask selection by the interrupt flag, the out-of-range cause code, machine traps ignoring delegation, and the stacked enable bit taken from the old privilege. They also cover the choice between the vector and the debug-exception address, and the fact that outputs hold between traps.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRV_USER = 2'b00,
        PRV_SUPV = 2'b01,
        PRV_MACH = 2'b11
    } prv_e;

    typedef enum logic [1:0] {
        DEST_NONE  = 2'd0,
        DEST_SUPV  = 2'd1,
        DEST_MACH  = 2'd2,
        DEST_DEBUG = 2'd3
    } dest_e;

    // status word bit positions (stacked enable selected by privilege index)
    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;

    localparam int          BRK_CODE  = 3;
    localparam logic [2:0]  DBGC_SWBP = 3'd1;

    typedef struct packed {
        dest_e dest;
        logic  wr_badaddr;
        logic  clr_resv;
    } route_t;

    function automatic logic prv_delegable(input logic [1:0] prv);
        return (prv == PRV_USER) || (prv == PRV_SUPV);
    endfunction

    function automatic logic [1:0] dest_prv(input dest_e d);
        return (d == DEST_SUPV) ? PRV_SUPV : PRV_MACH;
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause,
    input  logic            addr_vld,
    input  logic [1:0]      prv,
    input  logic [XLEN-1:0] medeleg,
    input  logic [XLEN-1:0] mideleg,
    input  logic            dbg_attached,
    output route_t          route
);
    localparam int IDXW = $clog2(XLEN);

    logic              is_irq;
    logic [XLEN-2:0]   code;
    logic [IDXW-1:0]   idx;
    logic              in_range;
    logic [XLEN-1:0]   mask;
    logic              deleg_hit;
    logic              brk_dbg;

    always_comb begin
        is_irq    = cause[XLEN-1];
        code      = cause[XLEN-2:0];
        idx       = code[IDXW-1:0];
        in_range  = ((code >> IDXW) == '0);
        mask      = is_irq ? mideleg : medeleg;
        deleg_hit = in_range && mask[idx];
        brk_dbg   = !is_irq && (code == (XLEN-1)'(BRK_CODE)) && dbg_attached;

        if (brk_dbg)
            route.dest = DEST_DEBUG;
        else if (prv_delegable(prv) && deleg_hit)
            route.dest = DEST_SUPV;
        else
            route.dest = DEST_MACH;

        route.wr_badaddr = addr_vld && !brk_dbg;
        route.clr_resv   = !brk_dbg;
    end
endmodule

// File: rtl/trap_stack.sv
module trap_stack
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] status_in,
    input  logic [1:0]      prv,
    input  dest_e           dest,
    output logic [XLEN-1:0] status_out
);
    logic old_ie;

    always_comb begin
        old_ie     = status_in[prv];
        status_out = status_in;
        case (dest)
            DEST_SUPV: begin
                status_out[ST_SPIE] = old_ie;
                status_out[ST_SPP]  = prv[0];
                status_out[ST_SIE]  = 1'b0;
            end
            DEST_MACH: begin
                status_out[ST_MPIE]              = old_ie;
                status_out[ST_MPP_LO+1:ST_MPP_LO] = prv;
                status_out[ST_MIE]               = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_entry_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] DBG_ROM_ADDR = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC_ADDR = 'h808
) (
    input  dest_e           dest,
    input  logic [XLEN-1:0] stvec,
    input  logic [XLEN-1:0] mtvec,
    input  logic [2:0]      dbg_cause,
    output logic [XLEN-1:0] pc
);
    always_comb begin
        case (dest)
            DEST_SUPV:  pc = stvec;
            DEST_DEBUG: pc = DBG_ROM_ADDR;
            default:    pc = (dbg_cause != 3'd0) ? DBG_EXC_ADDR : mtvec;
        endcase
    end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
    import trap_entry_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] DBG_ROM_ADDR = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC_ADDR = 'h808
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_addr,
    input  logic            trap_addr_vld,
    input  logic [XLEN-1:0] trap_epc,
    input  logic [1:0]      cur_prv,
    input  logic [XLEN-1:0] cur_status,
    input  logic [XLEN-1:0] stvec_in,
    input  logic [XLEN-1:0] mtvec_in,
    input  logic [XLEN-1:0] medeleg_in,
    input  logic [XLEN-1:0] mideleg_in,
    input  logic [2:0]      dbg_cause_in,
    input  logic            dbg_attached,
    output logic            commit_vld,
    output logic [1:0]      commit_dest,
    output logic [XLEN-1:0] nxt_pc,
    output logic [1:0]      nxt_prv,
    output logic [XLEN-1:0] nxt_status,
    output logic [XLEN-1:0] cause_out,
    output logic [XLEN-1:0] epc_out,
    output logic            badaddr_wr,
    output logic [XLEN-1:0] badaddr_out,
    output logic [2:0]      dbg_cause_out,
    output logic [1:0]      dbg_prv_out,
    output logic            resv_clear
);
    route_t          rt;
    logic [XLEN-1:0] st_new;
    logic [XLEN-1:0] pc_new;

    trap_route #(.XLEN(XLEN)) u_route (
        .cause        (trap_cause),
        .addr_vld     (trap_addr_vld),
        .prv          (cur_prv),
        .medeleg      (medeleg_in),
        .mideleg      (mideleg_in),
        .dbg_attached (dbg_attached),
        .route        (rt)
    );

    trap_stack #(.XLEN(XLEN)) u_stack (
        .status_in  (cur_status),
        .prv        (cur_prv),
        .dest       (rt.dest),
        .status_out (st_new)
    );

    trap_vector #(
        .XLEN         (XLEN),
        .DBG_ROM_ADDR (DBG_ROM_ADDR),
        .DBG_EXC_ADDR (DBG_EXC_ADDR)
    ) u_vector (
        .dest      (rt.dest),
        .stvec     (stvec_in),
        .mtvec     (mtvec_in),
        .dbg_cause (dbg_cause_in),
        .pc        (pc_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_vld    <= 1'b0;
            commit_dest   <= DEST_NONE;
            nxt_pc        <= '0;
            nxt_prv       <= '0;
            nxt_status    <= '0;
            cause_out     <= '0;
            epc_out       <= '0;
            badaddr_wr    <= 1'b0;
            badaddr_out   <= '0;
            dbg_cause_out <= '0;
            dbg_prv_out   <= '0;
            resv_clear    <= 1'b0;
        end else begin
            commit_vld <= trap_req;
            badaddr_wr <= trap_req && rt.wr_badaddr;
            resv_clear <= trap_req && rt.clr_resv;
            if (trap_req) begin
                commit_dest <= rt.dest;
                nxt_pc      <= pc_new;
                nxt_prv     <= dest_prv(rt.dest);
                nxt_status  <= st_new;
                cause_out   <= trap_cause;
                epc_out     <= trap_epc;
                if (rt.wr_badaddr)
                    badaddr_out <= trap_addr;
                if (rt.dest == DEST_DEBUG) begin
                    dbg_cause_out <= DBGC_SWBP;
                    dbg_prv_out   <= cur_prv;
                end
            end
        end
    end

    a_r1_commit_after_req: assert property (@(posedge clk) disable iff (rst)
        commit_vld |-> $past(trap_req));
    a_r1_idle_no_commit: assert property (@(posedge clk) disable iff (rst)
        !trap_req |=> (!commit_vld && !badaddr_wr && !resv_clear));
    a_r3_supv_not_from_mach: assert property (@(posedge clk) disable iff (rst)
        (commit_vld && commit_dest == DEST_SUPV) |-> ($past(cur_prv) != PRV_MACH));
    a_r5_supv_entry: assert property (@(posedge clk) disable iff (rst)
        (commit_vld && commit_dest == DEST_SUPV) |-> (!nxt_status[ST_SIE] && nxt_prv == PRV_SUPV));
    a_r6_mach_entry: assert property (@(posedge clk) disable iff (rst)
        (commit_vld && commit_dest == DEST_MACH) |-> (!nxt_status[ST_MIE] && nxt_prv == PRV_MACH));
    a_r8_debug_keeps_status: assert property (@(posedge clk) disable iff (rst)
        (commit_vld && commit_dest == DEST_DEBUG) |-> (nxt_status == $past(cur_status) && !badaddr_wr));
    a_r9_resv_on_entry: assert property (@(posedge clk) disable iff (rst)
        resv_clear |-> (commit_vld && commit_dest != DEST_DEBUG));
    a_r4_badaddr_needs_addr: assert property (@(posedge clk) disable iff (rst)
        badaddr_wr |-> $past(trap_addr_vld));

endmodule

// File: tb/trap_entry_bench.sv
module trap_entry_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            trap_req = 1'b0;
    logic [XLEN-1:0] trap_cause = '0;
    logic [XLEN-1:0] trap_addr = '0;
    logic            trap_addr_vld = 1'b0;
    logic [XLEN-1:0] trap_epc = '0;
    logic [1:0]      cur_prv = 2'b00;
    logic [XLEN-1:0] cur_status = '0;
    logic [XLEN-1:0] stvec_in = 32'h1000;
    logic [XLEN-1:0] mtvec_in = 32'h2000;
    logic [XLEN-1:0] medeleg_in = '0;
    logic [XLEN-1:0] mideleg_in = '0;
    logic [2:0]      dbg_cause_in = '0;
    logic            dbg_attached = 1'b0;

    logic            commit_vld;
    logic [1:0]      commit_dest;
    logic [XLEN-1:0] nxt_pc;
    logic [1:0]      nxt_prv;
    logic [XLEN-1:0] nxt_status;
    logic [XLEN-1:0] cause_out;
    logic [XLEN-1:0] epc_out;
    logic            badaddr_wr;
    logic [XLEN-1:0] badaddr_out;
    logic [2:0]      dbg_cause_out;
    logic [1:0]      dbg_prv_out;
    logic            resv_clear;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry u_trap_entry (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_cause(trap_cause),
        .trap_addr(trap_addr), .trap_addr_vld(trap_addr_vld), .trap_epc(trap_epc),
        .cur_prv(cur_prv), .cur_status(cur_status), .stvec_in(stvec_in),
        .mtvec_in(mtvec_in), .medeleg_in(medeleg_in), .mideleg_in(mideleg_in),
        .dbg_cause_in(dbg_cause_in), .dbg_attached(dbg_attached),
        .commit_vld(commit_vld), .commit_dest(commit_dest), .nxt_pc(nxt_pc),
        .nxt_prv(nxt_prv), .nxt_status(nxt_status), .cause_out(cause_out),
        .epc_out(epc_out), .badaddr_wr(badaddr_wr), .badaddr_out(badaddr_out),
        .dbg_cause_out(dbg_cause_out), .dbg_prv_out(dbg_prv_out),
        .resv_clear(resv_clear)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // pulse trap_req for one edge; return at the negedge after the commit edge
    task automatic fire();
        @(negedge clk);
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "commit_vld", commit_vld, 0);
        chk("R10", "commit_dest", commit_dest, 0);
        chk("R10", "nxt_pc", nxt_pc, 0);
        chk("R10", "nxt_status", nxt_status, 0);
        chk("R10", "resv_clear", resv_clear, 0);
    endtask

    task automatic t_supv_exception();
        cur_prv = 2'b00; cur_status = 32'h1;
        medeleg_in = 32'h100; mideleg_in = '0;
        trap_cause = 32'd8; trap_epc = 32'h4000; trap_addr_vld = 1'b0;
        fire();
        chk("R1", "commit_vld", commit_vld, 1);
        chk("R3", "dest", commit_dest, 1);
        chk("R4", "pc", nxt_pc, 32'h1000);
        chk("R4", "cause", cause_out, 8);
        chk("R4", "epc", epc_out, 32'h4000);
        chk("R4", "badaddr_wr", badaddr_wr, 0);
        chk("R5", "status", nxt_status, 32'h21);
        chk("R5", "prv", nxt_prv, 2'b01);
        chk("R9", "resv_clear", resv_clear, 1);
    endtask

    task automatic t_supv_interrupt();
        cur_prv = 2'b01; cur_status = 32'h2;
        mideleg_in = 32'h20; medeleg_in = '0;
        trap_cause = 32'h8000_0005; trap_epc = 32'h4100;
        trap_addr = 32'hDEAD; trap_addr_vld = 1'b1;
        fire();
        chk("R2", "dest", commit_dest, 1);
        chk("R5", "status", nxt_status, 32'h120);
        chk("R4", "badaddr_wr", badaddr_wr, 1);
        chk("R4", "badaddr", badaddr_out, 32'hDEAD);
        trap_addr_vld = 1'b0;
    endtask

    task automatic t_irq_uses_mideleg();
        cur_prv = 2'b01; cur_status = 32'h2;
        mideleg_in = '0; medeleg_in = 32'h20;
        trap_cause = 32'h8000_0005;
        fire();
        chk("R2", "dest", commit_dest, 2);
        chk("R6", "status", nxt_status, 32'h882);
        chk("R6", "prv", nxt_prv, 2'b11);
        chk("R7", "pc", nxt_pc, 32'h2000);
        chk("R6", "cause", cause_out, 32'h8000_0005);
    endtask

    task automatic t_from_mach();
        cur_prv = 2'b11; cur_status = 32'h8;
        medeleg_in = 32'hFFFF_FFFF; mideleg_in = 32'hFFFF_FFFF;
        trap_cause = 32'd5; trap_addr = 32'hBEEF; trap_addr_vld = 1'b1;
        trap_epc = 32'h4200;
        fire();
        chk("R3", "dest", commit_dest, 2);
        chk("R6", "status", nxt_status, 32'h1880);
        chk("R6", "badaddr", badaddr_out, 32'hBEEF);
        chk("R6", "epc", epc_out, 32'h4200);
        chk("R9", "resv_clear", resv_clear, 1);
        trap_addr_vld = 1'b0;
    endtask

    task automatic t_code_out_of_range();
        cur_prv = 2'b00; cur_status = 32'h1;
        medeleg_in = 32'hFFFF_FFFF; mideleg_in = 32'hFFFF_FFFF;
        trap_cause = 32'd40;
        fire();
        chk("R3", "dest", commit_dest, 2);
        chk("R6", "status", nxt_status, 32'h81);
    endtask

    task automatic t_debug_exc_addr();
        cur_prv = 2'b11; cur_status = '0; medeleg_in = '0;
        dbg_cause_in = 3'd2; trap_cause = 32'd2;
        fire();
        chk("R7", "pc", nxt_pc, 32'h808);
        dbg_cause_in = 3'd0;
    endtask

    task automatic t_breakpoint_debug();
        cur_prv = 2'b01; cur_status = 32'h2; medeleg_in = 32'h8;
        dbg_attached = 1'b1; trap_cause = 32'd3; trap_epc = 32'h4444;
        trap_addr_vld = 1'b1;
        fire();
        chk("R8", "dest", commit_dest, 3);
        chk("R8", "pc", nxt_pc, 32'h800);
        chk("R8", "prv", nxt_prv, 2'b11);
        chk("R8", "dbg_cause", dbg_cause_out, 1);
        chk("R8", "dbg_prv", dbg_prv_out, 2'b01);
        chk("R8", "dpc", epc_out, 32'h4444);
        chk("R8", "status", nxt_status, 32'h2);
        chk("R8", "badaddr_wr", badaddr_wr, 0);
        chk("R9", "resv_clear", resv_clear, 0);
        dbg_attached = 1'b0; trap_addr_vld = 1'b0;
    endtask

    task automatic t_breakpoint_no_debugger();
        cur_prv = 2'b00; cur_status = '0; medeleg_in = '0;
        trap_cause = 32'd3;
        fire();
        chk("R8", "dest", commit_dest, 2);
        chk("R7", "pc", nxt_pc, 32'h2000);
    endtask

    task automatic t_hold();
        logic [XLEN-1:0] pc_before;
        pc_before = nxt_pc;
        trap_cause = 32'd9; mtvec_in = 32'h3000;
        repeat (3) @(negedge clk);
        chk("R1", "commit_vld idle", commit_vld, 0);
        chk("R1", "pc hold", nxt_pc, pc_before);
        chk("R1", "resv idle", resv_clear, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_supv_exception();
        t_supv_interrupt();
        t_irq_uses_mideleg();
        t_from_mach();
        t_code_out_of_range();
        t_debug_exc_addr();
        t_breakpoint_debug();
        t_breakpoint_no_debugger();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule